// File: doc/BRIEF.md
# Receive-Only Byte Request Packer

This block drives the receive-only mode of an SPI host. Software writes a 16-bit byte count. While bytes remain, the block holds its shift-enable output high, so the shift engine clocks the bus with idle transmit data. Each byte the engine delivers is counted against the request and packed into a 32-bit word. The configured word length plays no part in this mode. Full words, and a shorter final word, are pushed toward the receive FIFO.

A 16-bit remaining-byte counter can be observed at all times. When the last pushed word holds fewer than four bytes, a 3-bit byte-valid output tells software how many of its low bytes are real. A receive interrupt pulse marks every word the FIFO accepts. A done pulse marks the byte that empties the counter. If the FIFO is full when a push arrives, the block raises an overflow pulse.

The push side uses valid/ready, but the block does not stall on back-pressure. `push_valid` is a single-cycle pulse. If `push_ready` is low in that cycle, the word is dropped and `overflow` pulses instead of `rx_irq`. The block never holds a word waiting for ready.

Top module: `rx_req_packer`

## Requirements
- R1: After reset, `todo` is 0, `shift_en` is 0, `push_valid` is 0 and `byte_valid` is 0.
- R2: A `req_wr` pulse while `tx_busy` is low loads `req_count` into `todo` at that edge, and `shift_en` is high from then while `todo` is non-zero. A `req_wr` while `tx_busy` is high is ignored.
- R3: Each `byte_vld` cycle taken while `todo` is non-zero lowers `todo` by one. Bytes offered while `todo` is 0 are ignored and produce no push.
- R4: Every fourth taken byte pushes a full word in the cycle after that byte. The earliest byte is in bits 31:24 and the latest in bits 7:0. `byte_valid` reads 0 for a full word.
- R5: The byte that brings `todo` to zero flushes any shorter word. With k bytes (1 to 3), the first byte sits in bits 8k-1 down to 8k-8, higher bits are 0, and `byte_valid` (status field 30:28 of the host) reads k from the push cycle onward.
- R6: A push cycle with `push_ready` low drops the word, pulses `overflow` and gives no `rx_irq`.
- R7: `rx_irq` pulses for one cycle for every word pushed while `push_ready` is high.
- R8: `done` pulses once, in the same cycle as the push of the request's final word.
- R9: A request written while a previous one is active replaces the remaining count rather than adding to it. Bytes already packed are kept.
- R10: A request of zero raises no `shift_en`, pushes no word and gives no `done`.
- R11: When `req_wr` and a taken byte share a cycle, the write sets `todo`, and the byte is still packed as a non-final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Request write strobe |
| req_count | input | 16 | Number of bytes to receive |
| tx_busy | input | 1 | Transmit data present; blocks requests |
| shift_en | output | 1 | Shift engine may clock the bus |
| byte_vld | input | 1 | One received byte is on byte_data |
| byte_data | input | 8 | Received byte |
| push_valid | output | 1 | Packed word pulse toward FIFO |
| push_ready | input | 1 | FIFO has room |
| push_data | output | 32 | Packed word |
| byte_valid | output | 3 | Valid bytes in last pushed short word, 0 if full |
| todo | output | 16 | Bytes still outstanding |
| rx_irq | output | 1 | Word accepted pulse |
| done | output | 1 | Request completed pulse |
| overflow | output | 1 | Push met a full FIFO |

## Verification
The bench sweeps every request length from 0 to 33 bytes, with bytes delivered either back-to-back or with an idle cycle between them. This covers every remainder modulo four and shows whether the flush and lane placement depend on delivery rate. Separate runs cover four cases: a rewrite during an active request, a write in the same cycle as a taken byte, a write blocked by transmit data, and stray bytes with nothing requested. These tell replacement apart from accumulation and blocked writes apart from accepted ones. A run with the FIFO full separates dropped words from accepted ones.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int BYTE_W = 8;

  // byte handed from the request controller to the packer
  typedef struct packed {
    logic                take;
    logic                last;
    logic [BYTE_W-1:0]   data;
  } rxp_byte_t;
endpackage

// File: rtl/rxp_req_ctl.sv
module rxp_req_ctl
  import rxp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              tx_busy,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  output rxp_byte_t         byte_o,
  output logic [CNT_W-1:0]  todo,
  output logic              shift_en,
  output logic              done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] todo_q;
  logic             done_q;
  logic             load;
  logic             take;

  assign load = req_wr && !tx_busy;
  assign take = byte_vld && (todo_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      todo_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= take && !load && (todo_q == ONE);
      if (load)      todo_q <= req_count;
      else if (take) todo_q <= todo_q - ONE;
    end
  end

  always_comb begin
    byte_o.take = take;
    byte_o.last = take && !load && (todo_q == ONE);
    byte_o.data = byte_data;
  end

  assign todo     = todo_q;
  assign shift_en = (todo_q != '0);
  assign done     = done_q;

  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load) |=> (todo_q == $past(todo_q) - ONE));
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (todo_q == $past(req_count)));
  p_busy_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && tx_busy && !take) |=> $stable(todo_q));
  p_done_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (todo_q == '0));
endmodule

// File: rtl/rxp_packer.sv
module rxp_packer
  import rxp_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int BV_W       = $clog2(WORD_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  rxp_byte_t                   byte_i,
  input  logic                        push_ready,
  output logic                        push_valid,
  output logic [WORD_BYTES*BYTE_W-1:0] push_data,
  output logic [BV_W-1:0]             byte_valid,
  output logic                        overflow,
  output logic                        rx_irq
);
  localparam int              WORD_W = WORD_BYTES * BYTE_W;
  localparam logic [BV_W-1:0] FULL   = BV_W'(WORD_BYTES);

  logic [WORD_W-1:0] acc_q, next_acc, data_q;
  logic [BV_W-1:0]   cnt_q, next_cnt, bv_q;
  logic              push_q, flush;

  // shift left so the earliest byte ends in the highest filled lane
  generate
    if (WORD_BYTES > 1) begin : g_multi
      assign next_acc = {acc_q[WORD_W-BYTE_W-1:0], byte_i.data};
    end else begin : g_single
      assign next_acc = byte_i.data;
    end
  endgenerate

  assign next_cnt = cnt_q + BV_W'(1);
  assign flush    = byte_i.take && ((next_cnt == FULL) || byte_i.last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      data_q <= '0;
      bv_q   <= '0;
      push_q <= 1'b0;
    end else begin
      push_q <= flush;
      if (flush) begin
        data_q <= next_acc;
        bv_q   <= (next_cnt == FULL) ? '0 : next_cnt;
        acc_q  <= '0;
        cnt_q  <= '0;
      end else if (byte_i.take) begin
        acc_q <= next_acc;
        cnt_q <= next_cnt;
      end
    end
  end

  assign push_valid = push_q;
  assign push_data  = data_q;
  assign byte_valid = bv_q;
  assign overflow   = push_q && !push_ready;
  assign rx_irq     = push_q && push_ready;

  p_fill_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < FULL);
  p_short_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> (bv_q < FULL));
  p_upper_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_q && bv_q != '0) |-> ((data_q >> (BYTE_W * bv_q)) == '0));
  p_push_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> push_q);
endmodule

// File: rtl/rx_req_packer.sv
module rx_req_packer
  import rxp_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int WORD_BYTES = 4,
  parameter int BV_W       = $clog2(WORD_BYTES + 1),
  parameter int WORD_W     = WORD_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              tx_busy,
  output logic              shift_en,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [WORD_W-1:0] push_data,
  output logic [BV_W-1:0]   byte_valid,
  output logic [CNT_W-1:0]  todo,
  output logic              rx_irq,
  output logic              done,
  output logic              overflow
);
  rxp_byte_t byte_w;

  rxp_req_ctl #(.CNT_W(CNT_W)) i_ctl (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_count(req_count),
    .tx_busy(tx_busy), .byte_vld(byte_vld), .byte_data(byte_data),
    .byte_o(byte_w), .todo(todo), .shift_en(shift_en), .done(done)
  );

  rxp_packer #(.WORD_BYTES(WORD_BYTES), .BV_W(BV_W)) i_pack (
    .clk(clk), .rst_n(rst_n), .byte_i(byte_w), .push_ready(push_ready),
    .push_valid(push_valid), .push_data(push_data), .byte_valid(byte_valid),
    .overflow(overflow), .rx_irq(rx_irq)
  );

  p_done_with_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> push_valid);
  p_idle_no_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !push_valid) |=> !push_valid);
endmodule

// File: tb/test_rx_req_packer.sv
`timescale 1ns/1ps
module test_rx_req_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_wr = 1'b0;
  logic [15:0] req_count = '0;
  logic        tx_busy = 1'b0;
  logic        shift_en;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        push_valid;
  logic        push_ready = 1'b1;
  logic [31:0] push_data;
  logic [2:0]  byte_valid;
  logic [15:0] todo;
  logic        rx_irq, done, overflow;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rx_req_packer i_rx_req_packer (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_count(req_count),
    .tx_busy(tx_busy), .shift_en(shift_en), .byte_vld(byte_vld),
    .byte_data(byte_data), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .byte_valid(byte_valid), .todo(todo),
    .rx_irq(rx_irq), .done(done), .overflow(overflow)
  );

  // monitor
  logic        mon_clr = 1'b0;
  int          npush, nirq, novf, ndone;
  logic [31:0] mon_data [16];
  logic [2:0]  mon_bv   [16];
  logic [7:0]  sent     [64];
  int          nsent;

  always @(negedge clk) begin
    if (mon_clr) begin
      npush = 0; nirq = 0; novf = 0; ndone = 0;
    end else begin
      if (push_valid) begin
        if (npush < 16) begin
          mon_data[npush] = push_data;
          mon_bv[npush]   = byte_valid;
        end
        npush++;
      end
      if (rx_irq)   nirq++;
      if (overflow) novf++;
      if (done)     ndone++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); #1 mon_clr = 1'b1; nsent = 0;
    @(posedge clk); #1 mon_clr = 1'b0;
  endtask

  task automatic write_req(input int n);
    @(posedge clk); #1 req_wr = 1'b1; req_count = 16'(n);
    @(posedge clk); #1 req_wr = 1'b0;
  endtask

  task automatic feed(input int n, input bit gap, input int seed);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      byte_vld  = 1'b1;
      byte_data = 8'((seed * 13 + nsent * 29) ^ 8'hA5);
      sent[nsent] = byte_data;
      nsent++;
      if (gap) begin
        @(posedge clk); #1 byte_vld = 1'b0;
      end
    end
    @(posedge clk); #1 byte_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // expected grouping of sent bytes in fours; the last group may be short
  task automatic check_pack(input int total, input string tag);
    int ng;
    ng = (total + 3) / 4;
    chk(npush == ng, {tag, " entry count"}, 32'(npush), 32'(ng));
    chk(nirq == ng, "R7 irq count", 32'(nirq), 32'(ng));
    chk(novf == 0, "R6 no overflow", 32'(novf), 0);
    chk(ndone == (total != 0), "R8 done count", 32'(ndone), 32'(total != 0));
    for (int g = 0; g < ng && g < 16; g++) begin
      int k;
      logic [31:0] ev;
      k = (total - 4 * g >= 4) ? 4 : total - 4 * g;
      ev = '0;
      for (int j = 0; j < k; j++) ev = (ev << 8) | 32'(sent[4 * g + j]);
      chk(mon_data[g] == ev, (k == 4) ? "R4 full word" : "R5 short word",
          mon_data[g], ev);
      chk(mon_bv[g] == 3'(k % 4), "R5 byte_valid", 32'(mon_bv[g]), 32'(k % 4));
    end
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    nsent = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(todo == 0, "R1 todo", 32'(todo), 0);
    chk(shift_en == 0, "R1 shift_en", 32'(shift_en), 0);
    chk(push_valid == 0, "R1 push_valid", 32'(push_valid), 0);
    chk(byte_valid == 0, "R1 byte_valid", 32'(byte_valid), 0);

    // sweep of lengths and delivery rates
    for (int n = 0; n <= 33; n++) begin
      clear_mon();
      write_req(n);
      @(negedge clk);
      chk(todo == 16'(n), "R2 load", 32'(todo), 32'(n));
      chk(shift_en == (n != 0), "R10 shift_en", 32'(shift_en), 32'(n != 0));
      if (n > 1) begin
        feed(1, n[0], n);
        @(negedge clk);
        chk(todo == 16'(n - 1), "R3 count down", 32'(todo), 32'(n - 1));
        feed(n - 1, n[0], n);
      end else begin
        feed(n, n[0], n);
      end
      idle(3);
      chk(todo == 0, "R3 empty", 32'(todo), 0);
      check_pack(n, (n % 4 == 0) ? "R4" : "R5");
    end

    // stray bytes with no request are ignored
    clear_mon();
    feed(5, 1'b0, 7);
    idle(3);
    chk(npush == 0, "R3 stray bytes", 32'(npush), 0);
    chk(todo == 0, "R3 stray todo", 32'(todo), 0);

    // request blocked by transmit data
    tx_busy = 1'b1;
    write_req(5);
    @(negedge clk);
    chk(todo == 0, "R2 blocked todo", 32'(todo), 0);
    chk(shift_en == 0, "R2 blocked shift_en", 32'(shift_en), 0);
    tx_busy = 1'b0;

    // rewrite replaces remaining count, packed bytes kept
    clear_mon();
    write_req(10);
    feed(3, 1'b1, 3);
    write_req(2);
    @(negedge clk);
    chk(todo == 2, "R9 replace", 32'(todo), 2);
    feed(2, 1'b0, 3);
    idle(3);
    check_pack(5, "R9");

    // write and byte in the same cycle
    clear_mon();
    write_req(8);
    feed(1, 1'b1, 9);
    @(posedge clk); #1;
    req_wr = 1'b1; req_count = 16'd3; byte_vld = 1'b1;
    byte_data = 8'h3C; sent[nsent] = 8'h3C; nsent++;
    @(posedge clk); #1 req_wr = 1'b0; byte_vld = 1'b0;
    @(negedge clk);
    chk(todo == 3, "R11 write wins", 32'(todo), 3);
    feed(3, 1'b0, 9);
    idle(3);
    check_pack(5, "R11");

    // full FIFO drops words
    clear_mon();
    push_ready = 1'b0;
    write_req(6);
    feed(6, 1'b0, 11);
    idle(3);
    push_ready = 1'b1;
    chk(novf == 2, "R6 overflow count", 32'(novf), 2);
    chk(nirq == 0, "R6 no irq", 32'(nirq), 0);
    chk(ndone == 1, "R8 done on drop", 32'(ndone), 1);

    // zero request after all that
    clear_mon();
    write_req(0);
    idle(4);
    chk(npush == 0 && ndone == 0, "R10 zero request", 32'(npush + ndone), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule